// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Controller

This block is the slave-side power-mode logic of a serial (SPI) memory. It samples chip select, serial clock and serial data in on the system clock. It assembles 8-bit command opcodes and acts on two of them: the opcode that puts the part to sleep, and the opcode that wakes it and reads back its identification byte. Every other opcode is passed to the array controller as a one-cycle pulse, but only while the part is fully awake.

A sleep request counts only when chip select returns high exactly at the end of the opcode byte and the array is not busy. It takes effect after a programmable settle delay. While asleep, the controller drops every opcode except the wake opcode, so a stray write or erase cannot reach the array. A wake command releases the part when chip select rises. A second programmable delay then runs before new commands are forwarded. The identification byte is driven on serial data out after three dummy bytes, whether or not the part was asleep.

Top module: `spi_pd_ctrl`

## Requirements
- R1: After synchronous reset the controller is awake: `pd_status`=0, `so_oe`=0 and `instr_valid`=0.
- R2: Opcodes are taken MSB first on rising SCK while CS# is low. In the awake state, each completed opcode other than 0xB9 and 0xAB gives exactly one `instr_valid` pulse, one clock wide, with the opcode on `instr_op`.
- R3: If CS# rises right after the 8th bit of opcode 0xB9, `pd_status` rises TDP_CYC clocks (plus pin synchronisation latency) later, and not before.
- R4: A 0xB9 frame closed after 7 or 9 bits leaves the controller awake.
- R5: A 0xB9 frame closed while `busy` is high is ignored, and the controller stays awake.
- R6: While asleep, no opcode (0x06, 0xB9 or any other) produces `instr_valid`, and `pd_status` stays high.
- R7: In a frame whose opcode is 0xAB, `so_oe` rises on the falling SCK edge after bit 32 (opcode plus 3 dummy bytes). SIG_BYTE is then driven MSB first, one bit per falling edge, for 8 bits. At all other times `so_oe` is 0.
- R8: While asleep, a 0xAB frame of at least 8 bits drops `pd_status` when CS# rises. Opcodes are forwarded again only after a further TRES_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low (asynchronous to clk) |
| sck | input | 1 | Serial clock (asynchronous to clk) |
| si | input | 1 | Serial data in |
| busy | input | 1 | Array write/erase cycle in progress |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| instr_valid | output | 1 | One-clock pulse: forwarded opcode available |
| instr_op | output | 8 | Forwarded opcode |
| pd_status | output | 1 | High while in deep power-down |

## Verification
A wrong power state shows up at the ports within one frame. A controller stuck asleep swallows the next ordinary opcode, so `instr_valid` never fires. A controller that wrongly thinks it is awake forwards an opcode it should drop. An off-by-one in the bit counter shows as a sleep entry on a 7- or 9-bit frame, or as the identification byte shifted by one falling edge. A wrong delay counter shows as `pd_status` rising early or late against the TDP_CYC window.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;
  typedef enum logic [1:0] {
    PS_AWAKE  = 2'd0,
    PS_ENTER  = 2'd1,
    PS_ASLEEP = 2'd2,
    PS_RESUME = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings the three serial pins into the clk domain and flags their edges.
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_q
);
  // bit 0 = cs_n, bit 1 = sck, bit 2 = si
  localparam logic [2:0] IDLE = 3'b001;
  logic [2:0] chain [STAGES];
  logic [2:0] prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= IDLE;
        else if (g == 0) chain[g] <= {si, sck, cs_n};
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else prev <= chain[STAGES-1];
  end

  assign cs_low   = ~chain[STAGES-1][0];
  assign cs_fall  = prev[0] & ~chain[STAGES-1][0];
  assign cs_rise  = ~prev[0] & chain[STAGES-1][0];
  assign sck_rise = ~prev[1] & chain[STAGES-1][1];
  assign sck_fall = prev[1] & ~chain[STAGES-1][1];
  assign si_q     = chain[STAGES-1][2];
endmodule

// File: rtl/spi_frame_rx.sv
// Counts frame bits, latches the opcode and drives the identification byte.
module spi_frame_rx #(
  parameter int          CNT_W       = 6,
  parameter int          DUMMY_BYTES = 3,
  parameter logic [7:0]  WAKE_OP     = 8'hAB,
  parameter logic [7:0]  SIG_BYTE    = 8'h13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_low,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             si_q,
  output logic             byte_done,
  output logic [7:0]       opcode,
  output logic             frame_end,
  output logic [CNT_W-1:0] end_bits,
  output logic             so,
  output logic             so_oe
);
  localparam int SIG_START = 8 * (1 + DUMMY_BYTES);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] sig_off;
  logic             in_sig;

  assign sig_off = bitcnt - CNT_W'(SIG_START);
  assign in_sig  = (opcode == WAKE_OP) &&
                   (bitcnt >= CNT_W'(SIG_START)) &&
                   (bitcnt <  CNT_W'(SIG_START + 8));

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt    <= '0;
      shreg     <= '0;
      opcode    <= '0;
      byte_done <= 1'b0;
      frame_end <= 1'b0;
      end_bits  <= '0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      frame_end <= 1'b0;
      if (cs_fall) begin
        bitcnt <= '0;
        so_oe  <= 1'b0;
      end else if (cs_rise) begin
        frame_end <= 1'b1;
        end_bits  <= bitcnt;
        so_oe     <= 1'b0;
      end else if (cs_low) begin
        if (sck_rise) begin
          shreg <= {shreg[6:0], si_q};
          if (bitcnt != SAT) bitcnt <= bitcnt + 1'b1;
          if (bitcnt == CNT_W'(7)) begin
            opcode    <= {shreg[6:0], si_q};
            byte_done <= 1'b1;
          end
        end else if (sck_fall) begin
          so_oe <= in_sig;
          if (in_sig) so <= SIG_BYTE[~sig_off[2:0]];
        end
      end
    end
  end

  // R7: data out is only enabled inside a selected frame
  p_so_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> $past(cs_low));
endmodule

// File: rtl/spi_pd_fsm.sv
// Power state sequencing with settle and resume delays.
module spi_pd_fsm
  import spi_pd_pkg::*;
#(
  parameter int TDP_CYC  = 300,
  parameter int TRES_CYC = 3000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_cmd,
  input  logic       wake_cmd,
  input  logic       busy,
  output pwr_state_t state
);
  localparam int MAXD = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
  localparam int TW   = $clog2(MAXD + 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_AWAKE;
      tmr   <= '0;
    end else begin
      unique case (state)
        PS_AWAKE: if (sleep_cmd && !busy) begin
          state <= PS_ENTER;
          tmr   <= TW'(TDP_CYC - 1);
        end
        PS_ENTER: if (tmr == '0) state <= PS_ASLEEP;
                  else tmr <= tmr - 1'b1;
        PS_ASLEEP: if (wake_cmd) begin
          state <= PS_RESUME;
          tmr   <= TW'(TRES_CYC - 1);
        end
        PS_RESUME: if (tmr == '0) state <= PS_AWAKE;
                   else tmr <= tmr - 1'b1;
        default: state <= PS_AWAKE;
      endcase
    end
  end

  // R3: sleep is reached only through an expired settle delay
  p_sleep_after_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ASLEEP && $past(state) != PS_ASLEEP) |->
      ($past(state) == PS_ENTER && $past(tmr) == '0));
  // R5: a busy array keeps the controller awake
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (state == PS_AWAKE && busy) |=> state != PS_ENTER);
  // R8: resume follows only from sleep
  p_resume_from_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    (state == PS_RESUME && $past(state) != PS_RESUME) |-> $past(state) == PS_ASLEEP);
endmodule

// File: rtl/spi_pd_ctrl.sv
module spi_pd_ctrl
  import spi_pd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DUMMY_BYTES = 3,
  parameter int         TDP_CYC     = 300,
  parameter int         TRES_CYC    = 3000,
  parameter logic [7:0] SLEEP_OP    = 8'hB9,
  parameter logic [7:0] WAKE_OP     = 8'hAB,
  parameter logic [7:0] SIG_BYTE    = 8'h13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       busy,
  output logic       so,
  output logic       so_oe,
  output logic       instr_valid,
  output logic [7:0] instr_op,
  output logic       pd_status
);
  localparam int CNT_W = $clog2(8 * (2 + DUMMY_BYTES) + 8);

  logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall, si_q;
  logic byte_done, frame_end;
  logic [7:0] opcode;
  logic [CNT_W-1:0] end_bits;
  logic sleep_cmd, wake_cmd;
  pwr_state_t state;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_q(si_q)
  );

  spi_frame_rx #(
    .CNT_W(CNT_W), .DUMMY_BYTES(DUMMY_BYTES),
    .WAKE_OP(WAKE_OP), .SIG_BYTE(SIG_BYTE)
  ) u_rx (
    .clk(clk), .rst(rst), .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_q(si_q),
    .byte_done(byte_done), .opcode(opcode), .frame_end(frame_end),
    .end_bits(end_bits), .so(so), .so_oe(so_oe)
  );

  assign sleep_cmd = frame_end && (end_bits == CNT_W'(8)) && (opcode == SLEEP_OP);
  assign wake_cmd  = frame_end && (end_bits >= CNT_W'(8)) && (opcode == WAKE_OP);

  spi_pd_fsm #(.TDP_CYC(TDP_CYC), .TRES_CYC(TRES_CYC)) u_fsm (
    .clk(clk), .rst(rst), .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd),
    .busy(busy), .state(state)
  );

  assign pd_status = (state == PS_ASLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_valid <= 1'b0;
      instr_op    <= '0;
    end else begin
      instr_valid <= byte_done && (state == PS_AWAKE) &&
                     (opcode != SLEEP_OP) && (opcode != WAKE_OP);
      if (byte_done) instr_op <= opcode;
    end
  end

  // R1: the first cycle after reset is awake and quiet
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1 && !rst)
      p_reset_awake_r1: assert (state == PS_AWAKE && !so_oe && !instr_valid);
  end
  // R2: forwarded opcodes are single-cycle pulses
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> !instr_valid);
  // R6: nothing is forwarded while asleep
  p_no_fwd_asleep_r6: assert property (@(posedge clk) disable iff (rst)
    pd_status |-> !instr_valid);
endmodule

// File: tb/spi_pd_ctrl_test.sv
module spi_pd_ctrl_test;
  localparam int TDP  = 40;
  localparam int TRES = 200;
  localparam logic [7:0] SIG = 8'hC5;
  localparam int NV = 9;
  // [15:8] opcode, [7:4] bit count, [3] busy, [2] expect asleep, [1] expect pulse
  localparam logic [15:0] VEC [NV] = '{
    {8'h06, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h03, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hB9, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hB9, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hB9, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hB9, 4'd8, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hC7, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hAB, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hB8, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
  logic so, so_oe, instr_valid, pd_status;
  logic [7:0] instr_op;
  int total = 0, bad = 0, vcnt = 0;
  logic [7:0] last_op = '0;

  always #5 clk = ~clk;

  spi_pd_ctrl #(.TDP_CYC(TDP), .TRES_CYC(TRES), .SIG_BYTE(SIG)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .so(so), .so_oe(so_oe), .instr_valid(instr_valid), .instr_op(instr_op),
    .pd_status(pd_status)
  );

  always @(posedge clk) if (!rst && instr_valid) begin
    vcnt    <= vcnt + 1;
    last_op <= instr_op;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b);
    si = b; wclk(4); sck = 1'b1; wclk(8); sck = 1'b0; wclk(4);
  endtask

  task automatic read_bit();
    sck = 1'b1; wclk(8); sck = 1'b0; wclk(4);
  endtask

  task automatic frame(input logic [7:0] op, input int nbits);
    cs_n = 1'b0; wclk(8);
    for (int i = 0; i < nbits; i++) spi_bit(i < 8 ? op[7-i] : 1'b0);
    cs_n = 1'b1; wclk(8);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int base;
    logic [15:0] v;
    wclk(5); rst = 1'b0; wclk(2);
    // R1 reset state
    chk("R1 pd_status", pd_status, 0);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 instr_valid", instr_valid, 0);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      busy = v[3];
      base = vcnt;
      frame(v[15:8], int'(v[7:4]));
      busy = 1'b0;
      wclk(TDP + 20);
      chk("R2 pulse count", vcnt - base, {31'd0, v[1]});
      if (v[1]) chk("R2 opcode", last_op, v[15:8]);
      if (v[3]) chk("R5 busy sleep", pd_status, v[2]);
      else if (v[15:8] == 8'hB9 && v[7:4] != 4'd8) chk("R4 bad count", pd_status, v[2]);
      else chk("R3 sleep entry", pd_status, v[2]);
      if (pd_status) begin
        frame(8'hAB, 8);
        wclk(TRES + 20);
        chk("R8 wake", pd_status, 0);
      end
    end

    // R3 delay window
    frame(8'hB9, 8);
    wclk(15);
    chk("R3 not early", pd_status, 0);
    wclk(40);
    chk("R3 after delay", pd_status, 1);

    // R6 asleep filtering
    base = vcnt;
    frame(8'h06, 8); wclk(20);
    chk("R6 no pulse", vcnt - base, 0);
    chk("R6 stays asleep", pd_status, 1);
    frame(8'hB9, 8); wclk(60);
    chk("R6 sleep op ignored", pd_status, 1);

    // R7 identification byte, R8 wake on CS# rise
    cs_n = 1'b0; wclk(8);
    for (int i = 0; i < 31; i++) spi_bit(i < 8 ? 8'hAB >> (7 - i) : 1'b0);
    chk("R7 oe during dummy", so_oe, 0);
    spi_bit(1'b0);
    chk("R7 oe", so_oe, 1);
    chk("R7 sig bit7", so, SIG[7]);
    for (int i = 6; i >= 0; i--) begin
      read_bit();
      chk("R7 sig bit", so, SIG[i]);
    end
    read_bit();
    chk("R7 oe after byte", so_oe, 0);
    chk("R8 asleep until CS# rise", pd_status, 1);
    cs_n = 1'b1; wclk(8);
    chk("R8 awake", pd_status, 0);
    base = vcnt;
    frame(8'h06, 8); wclk(10);
    chk("R8 blocked during resume", vcnt - base, 0);
    wclk(TRES);
    base = vcnt;
    frame(8'h06, 8); wclk(10);
    chk("R8 forwarded after resume", vcnt - base, 1);
    chk("R7 oe idle", so_oe, 0);

    finish_run();
  end
endmodule